// File: doc/BRIEF.md
# Shared-window word store and PHY register access controller

This block gives a host one small window of byte registers through which it reaches two separate word targets. One is a non-volatile style word store of 128 sixteen-bit words, and the other is the 32-entry register file of an on-chip transceiver. Both are modelled inside the block as plain memories. The host loads a target offset and, for a write, a 16-bit data word. It then writes a command byte that says read or write, which target to use and whether store writes are allowed. It polls a busy bit until it clears, writes zero to the command byte, and for a read fetches the two data bytes.

Each command takes a fixed number of clocks, set by a parameter. During that time the block works only on copies of the offset, the data and the command bits that it captured when the command was accepted. The host may therefore touch the window registers while the operation is running without disturbing it. Commands that ask for both directions at once are dropped. A transceiver access is carried out only when the transceiver-address field matches the internal unit.

Top module: `xreg_bridge`

## Requirements
- R1: After synchronous reset, every window register reads 0, the busy bit is 0 and `bus_rdata` is 0.
- R2: Window map: 0x0B is the command byte (bit 0 busy, read-only; bit 1 write; bit 2 read; bit 3 selects the transceiver file instead of the word store; bit 4 allows store writes). 0x0C is the offset byte (bits 7:6 transceiver address). 0x0D is data bits 7:0 and 0x0E is data bits 15:8. Any other address reads 0 and ignores writes. `bus_rdata` is updated on the edge that samples `bus_rd` and otherwise holds its value.
- R3: A command write that sets exactly one of bits 1 and 2 while idle raises busy on that edge, and busy stays set for exactly LATENCY clocks (default 16). Back-to-back polls that start on the next cycle therefore see busy 16 times and then see it clear.
- R4: When a read finishes, the data register holds the selected word. The store word index is offset bits 6:0, and the transceiver index is offset bits 4:0.
- R5: A store write puts the captured data word into the array only when bit 4 was set in the command. Without bit 4 the write takes the same time and leaves the array unchanged.
- R6: Transceiver accesses act only when offset bits 7:6 equal 01. With any other value a read returns 0 and a write is dropped, and busy timing is unchanged.
- R7: While busy, writes to the command byte are ignored, including zero and new commands. The operation runs to completion with the offset, data and command it captured at the start, whatever the host writes meanwhile.
- R8: A command byte with both bits 1 and 2 set starts nothing: busy stays 0 and neither target nor the data register changes.
- R9: If a host write to a data byte falls on the same edge that a read finishes, the read result wins and is loaded as a whole.
- R10: The word store and the transceiver file are independent: the same offset in each holds its own word.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 8 | Window byte address |
| bus_wdata | input | 8 | Write data byte |
| bus_wr | input | 1 | Write strobe, one cycle per byte |
| bus_rd | input | 1 | Read strobe, one cycle per byte |
| bus_rdata | output | 8 | Registered read data |

## Verification
The two functions that can meet on one edge are the completion of a read, which loads the data register, and a host write to a data byte. The bench starts a read and counts LATENCY-1 idle cycles, so that its write strobe to the low data byte is sampled on exactly the edge where busy clears. It then expects the full stored word, with no trace of the written byte. A second, milder overlap is also checked: command, offset and data writes made while an operation is in flight must leave that operation's result untouched.

// File: rtl/xreg_pkg.sv
package xreg_pkg;
  localparam logic [7:0] WIN_CMD  = 8'h0B;
  localparam logic [7:0] WIN_OFS  = 8'h0C;
  localparam logic [7:0] WIN_DLO  = 8'h0D;
  localparam logic [7:0] WIN_DHI  = 8'h0E;
  localparam logic [1:0] PHY_UNIT = 2'b01;

  typedef struct packed {
    logic allow;  // bit 4
    logic xcvr;   // bit 3
    logic rd;     // bit 2
    logic wr;     // bit 1
  } cmd_t;
endpackage

// File: rtl/xreg_store.sv
module xreg_store #(
  parameter int WORDS = 128,
  parameter int WIDTH = 16,
  localparam int AW = $clog2(WORDS)
) (
  input  logic             clk,
  input  logic             wen,
  input  logic [AW-1:0]    idx,
  input  logic [WIDTH-1:0] wdat,
  output logic [WIDTH-1:0] q
);
  logic [WIDTH-1:0] mem [WORDS];

  always_ff @(posedge clk) begin
    if (wen) mem[idx] <= wdat;
    q <= mem[idx];
  end
endmodule

// File: rtl/xreg_seq.sv
module xreg_seq
  import xreg_pkg::*;
#(
  parameter int LATENCY = 16,
  localparam int CW = $clog2(LATENCY + 1)
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        start,
  input  cmd_t        start_cmd,
  input  logic [7:0]  start_ofs,
  input  logic [15:0] start_dat,
  output logic        busy,
  output logic        finish,
  output cmd_t        op_cmd,
  output logic [7:0]  op_ofs,
  output logic [15:0] op_dat
);
  logic [CW-1:0] remain;

  always_ff @(posedge clk) begin
    if (rst) begin
      busy   <= 1'b0;
      remain <= '0;
      op_cmd <= '0;
      op_ofs <= '0;
      op_dat <= '0;
    end else if (start && !busy) begin
      busy   <= 1'b1;
      remain <= CW'(LATENCY - 1);
      op_cmd <= start_cmd;
      op_ofs <= start_ofs;
      op_dat <= start_dat;
    end else if (busy) begin
      if (remain == '0) busy <= 1'b0;
      else              remain <= remain - 1'b1;
    end
  end

  assign finish = busy && (remain == '0);
endmodule

// File: rtl/xreg_hostregs.sv
module xreg_hostregs
  import xreg_pkg::*;
(
  input  logic        clk,
  input  logic        rst,
  input  logic [7:0]  bus_addr,
  input  logic [7:0]  bus_wdata,
  input  logic        bus_wr,
  input  logic        bus_rd,
  output logic [7:0]  bus_rdata,
  input  logic        busy,
  input  logic        load_rd,
  input  logic [15:0] rd_word,
  output logic        start,
  output cmd_t        cmd,
  output logic [7:0]  ofs,
  output logic [15:0] dat
);
  logic cmd_hit;
  assign cmd_hit = bus_wr && (bus_addr == WIN_CMD) && !busy;
  assign start   = cmd_hit && (bus_wdata[1] ^ bus_wdata[2]);

  always_ff @(posedge clk) begin
    if (rst) begin
      cmd <= '0;
      ofs <= '0;
      dat <= '0;
    end else begin
      if (cmd_hit) cmd <= bus_wdata[4:1];
      if (bus_wr && bus_addr == WIN_OFS) ofs <= bus_wdata;
      if (load_rd) dat <= rd_word;
      else if (bus_wr && bus_addr == WIN_DLO) dat[7:0]  <= bus_wdata;
      else if (bus_wr && bus_addr == WIN_DHI) dat[15:8] <= bus_wdata;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) bus_rdata <= '0;
    else if (bus_rd) begin
      case (bus_addr)
        WIN_CMD: bus_rdata <= {3'b000, cmd, busy};
        WIN_OFS: bus_rdata <= ofs;
        WIN_DLO: bus_rdata <= dat[7:0];
        WIN_DHI: bus_rdata <= dat[15:8];
        default: bus_rdata <= '0;
      endcase
    end
  end
endmodule

// File: rtl/xreg_bridge.sv
module xreg_bridge
  import xreg_pkg::*;
#(
  parameter int LATENCY  = 16,
  parameter int EE_WORDS = 128,
  parameter int PHY_REGS = 32,
  localparam int EE_AW  = $clog2(EE_WORDS),
  localparam int PHY_AW = $clog2(PHY_REGS)
) (
  input  logic       clk,
  input  logic       rst,
  input  logic [7:0] bus_addr,
  input  logic [7:0] bus_wdata,
  input  logic       bus_wr,
  input  logic       bus_rd,
  output logic [7:0] bus_rdata
);
  logic        start, busy, finish;
  cmd_t        cmd, op_cmd;
  logic [7:0]  ofs, op_ofs;
  logic [15:0] dat, op_dat, ee_q, phy_q, rd_word;
  logic        unit_ok, ee_wen, phy_wen;

  xreg_hostregs u_regs (
    .clk, .rst, .bus_addr, .bus_wdata, .bus_wr, .bus_rd, .bus_rdata,
    .busy, .load_rd(finish && op_cmd.rd), .rd_word,
    .start, .cmd, .ofs, .dat
  );

  xreg_seq #(.LATENCY(LATENCY)) u_seq (
    .clk, .rst, .start, .start_cmd(cmd_t'(bus_wdata[4:1])),
    .start_ofs(ofs), .start_dat(dat),
    .busy, .finish, .op_cmd, .op_ofs, .op_dat
  );

  assign unit_ok = (op_ofs[7:6] == PHY_UNIT);
  assign ee_wen  = finish && op_cmd.wr && !op_cmd.xcvr && op_cmd.allow;
  assign phy_wen = finish && op_cmd.wr && op_cmd.xcvr && unit_ok;
  assign rd_word = op_cmd.xcvr ? (unit_ok ? phy_q : 16'h0000) : ee_q;

  xreg_store #(.WORDS(EE_WORDS), .WIDTH(16)) u_ee (
    .clk, .wen(ee_wen), .idx(op_ofs[EE_AW-1:0]), .wdat(op_dat), .q(ee_q)
  );

  xreg_store #(.WORDS(PHY_REGS), .WIDTH(16)) u_phy (
    .clk, .wen(phy_wen), .idx(op_ofs[PHY_AW-1:0]), .wdat(op_dat), .q(phy_q)
  );
endmodule

// File: rtl/xreg_bridge_chk.sv
module xreg_bridge_chk #(
  parameter int LATENCY = 16
) (
  input logic       clk,
  input logic       rst,
  input logic [7:0] bus_addr,
  input logic [7:0] bus_wdata,
  input logic       bus_wr,
  input logic       bus_rd,
  input logic [7:0] bus_rdata,
  input logic       busy,
  input logic [7:0] op_ofs
);
  logic [15:0] run_len;
  logic        cmd_wr;

  assign cmd_wr = bus_wr && (bus_addr == 8'h0B) && !busy;

  always_ff @(posedge clk) begin
    if (rst)       run_len <= '0;
    else if (busy) run_len <= run_len + 1'b1;
    else           run_len <= '0;
  end

  // R3
  a_r3_busy_after_cmd: assert property (@(posedge clk) disable iff (rst)
    (cmd_wr && (bus_wdata[1] ^ bus_wdata[2])) |=> busy);
  // R3
  a_r3_busy_length: assert property (@(posedge clk) disable iff (rst)
    $fell(busy) |-> (run_len == 16'(LATENCY)));
  // R8
  a_r8_conflict_dropped: assert property (@(posedge clk) disable iff (rst)
    (cmd_wr && bus_wdata[1] && bus_wdata[2]) |=> !busy);
  // R7
  a_r7_operands_held: assert property (@(posedge clk) disable iff (rst)
    (busy && $past(busy)) |-> $stable(op_ofs));
  // R2
  a_r2_rdata_hold: assert property (@(posedge clk) disable iff (rst)
    !bus_rd |=> $stable(bus_rdata));
endmodule

bind xreg_bridge xreg_bridge_chk #(.LATENCY(LATENCY)) u_chk (
  .clk, .rst, .bus_addr, .bus_wdata, .bus_wr, .bus_rd, .bus_rdata,
  .busy, .op_ofs
);

// File: tb/xreg_bridge_test.sv
module xreg_bridge_test;
  localparam int CLK_PERIOD = 10;
  localparam int LAT = 16;
  localparam logic [7:0] A_CMD = 8'h0B, A_OFS = 8'h0C, A_DLO = 8'h0D, A_DHI = 8'h0E;

  logic clk = 0, rst = 1;
  logic [7:0] bus_addr = 0, bus_wdata = 0;
  logic bus_wr = 0, bus_rd = 0;
  logic [7:0] bus_rdata;

  int checks = 0, errors = 0;
  logic [15:0] ee_exp [128];
  logic [15:0] phy_exp [32];

  always #(CLK_PERIOD/2) clk = ~clk;

  xreg_bridge #(.LATENCY(LAT)) uut (
    .clk, .rst, .bus_addr, .bus_wdata, .bus_wr, .bus_rd, .bus_rdata
  );

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic bwr(input logic [7:0] a, input logic [7:0] d);
    bus_addr = a; bus_wdata = d; bus_wr = 1;
    @(negedge clk);
    bus_wr = 0;
  endtask

  task automatic brd(input logic [7:0] a, output logic [7:0] d);
    bus_addr = a; bus_rd = 1;
    @(negedge clk);
    bus_rd = 0;
    d = bus_rdata;
  endtask

  task automatic poll(input bit judge);
    logic [7:0] b;
    int n = 0;
    forever begin
      brd(A_CMD, b);
      if (!b[0] || n > 1000) break;
      n++;
    end
    if (judge) chk("R3 busy polls", 16'(n), 16'(LAT));
  endtask

  task automatic do_write(input bit xc, input logic [7:0] ofs, input logic [15:0] d, input bit allow);
    bwr(A_DLO, d[7:0]);
    bwr(A_DHI, d[15:8]);
    bwr(A_OFS, ofs);
    bwr(A_CMD, {3'b000, allow, xc, 2'b01, 1'b0});
    poll(1);
    bwr(A_CMD, 8'h00);
  endtask

  task automatic do_read(input bit xc, input logic [7:0] ofs, output logic [15:0] w);
    logic [7:0] lo, hi;
    bwr(A_OFS, ofs);
    bwr(A_CMD, {4'b0000, xc, 3'b100});
    poll(1);
    bwr(A_CMD, 8'h00);
    brd(A_DLO, lo);
    brd(A_DHI, hi);
    w = {hi, lo};
  endtask

  function automatic logic [15:0] pat(input int i, input int s);
    return 16'((i * 16'h0313) ^ (s * 16'h5AC7) ^ 16'h1E00);
  endfunction

  initial begin : wdog
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL R3 watchdog actual=hung expected=done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin : main
    logic [7:0] b;
    logic [15:0] w;
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);

    // R1 reset state
    chk("R1 rdata", 16'(bus_rdata), 16'h0);
    foreach (ee_exp[k]) ee_exp[k] = 'x;
    for (int a = 8'h0B; a <= 8'h0E; a++) begin
      brd(8'(a), b);
      chk("R1 reg", 16'(b), 16'h0);
    end
    // R2 unmapped
    bwr(8'h05, 8'hFF);
    brd(8'h05, b);
    chk("R2 unmapped", 16'(b), 16'h0);
    bwr(A_OFS, 8'h9C);
    brd(A_OFS, b);
    chk("R2 ofs readback", 16'(b), 16'h9C);
    repeat (3) @(negedge clk);
    chk("R2 rdata hold", 16'(bus_rdata), 16'h9C);

    // R4/R5 store sweep
    for (int i = 0; i < 128; i++) begin
      ee_exp[i] = pat(i, 1);
      do_write(0, 8'(i), ee_exp[i], 1);
    end
    for (int i = 0; i < 128; i++) begin
      do_read(0, 8'(i), w);
      chk("R4 store read", w, ee_exp[i]);
    end
    // R5 write without allow bit
    do_write(0, 8'd5, 16'hFFFF, 0);
    do_read(0, 8'd5, w);
    chk("R5 no-allow write", w, ee_exp[5]);

    // R4 transceiver sweep, unit 01
    for (int i = 0; i < 32; i++) begin
      phy_exp[i] = pat(i, 2);
      do_write(1, {2'b01, 6'(i)}, phy_exp[i], 0);
    end
    for (int i = 0; i < 32; i++) begin
      do_read(1, {2'b01, 6'(i)}, w);
      chk("R4 xcvr read", w, phy_exp[i]);
    end
    // R10 independence
    for (int i = 0; i < 32; i++) begin
      do_read(0, 8'(i), w);
      chk("R10 store intact", w, ee_exp[i]);
    end

    // R6 wrong unit address
    do_write(1, {2'b10, 6'd3}, 16'h1234, 1);
    do_read(1, {2'b01, 6'd3}, w);
    chk("R6 write dropped", w, phy_exp[3]);
    do_read(1, {2'b00, 6'd3}, w);
    chk("R6 read zero", w, 16'h0000);

    // R7 command/offset/data writes during a read
    bwr(A_OFS, 8'd7);
    bwr(A_CMD, 8'h04);
    bwr(A_CMD, 8'h00);
    bwr(A_CMD, 8'h12);
    bwr(A_OFS, 8'd9);
    poll(0);
    brd(A_CMD, b);
    chk("R7 cmd kept", 16'(b), 16'h0004);
    bwr(A_CMD, 8'h00);
    brd(A_DLO, b); w[7:0] = b;
    brd(A_DHI, b); w[15:8] = b;
    chk("R7 read operands", w, ee_exp[7]);
    // R7 data writes during a store write
    bwr(A_DLO, 8'h11); bwr(A_DHI, 8'h11);
    bwr(A_OFS, 8'd10);
    bwr(A_CMD, 8'h12);
    bwr(A_DLO, 8'h22); bwr(A_DHI, 8'h22);
    poll(0);
    bwr(A_CMD, 8'h00);
    ee_exp[10] = 16'h1111;
    do_read(0, 8'd10, w);
    chk("R7 write operands", w, 16'h1111);

    // R8 both direction bits
    bwr(A_DLO, 8'h77); bwr(A_DHI, 8'h77);
    bwr(A_OFS, 8'd11);
    bwr(A_CMD, 8'h16);
    brd(A_CMD, b);
    chk("R8 no busy", 16'(b[0]), 16'h0);
    brd(A_DLO, b);
    chk("R8 data kept", 16'(b), 16'h77);
    bwr(A_CMD, 8'h00);
    do_read(0, 8'd11, w);
    chk("R8 store intact", w, ee_exp[11]);

    // R9 data write on the completion edge
    bwr(A_OFS, 8'd20);
    bwr(A_CMD, 8'h04);
    repeat (LAT - 1) @(negedge clk);
    bwr(A_DLO, 8'hEE);
    poll(0);
    bwr(A_CMD, 8'h00);
    brd(A_DLO, b); w[7:0] = b;
    brd(A_DHI, b); w[15:8] = b;
    chk("R9 completion wins", w, ee_exp[20]);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule